// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Registers

This block sits beside a memory controller and records what a SECDED checker reports about 64-bit read data. Each cycle the checker may flag a correctable error, an uncorrectable error, or both. With each flag it gives the failing address, the 8-bit syndrome and the raw 64-bit word. The block keeps one snapshot per error class. Each snapshot holds the address, a status word carrying the syndrome, and the data split into low and high 32-bit halves. It also raises a level interrupt that software clears by writing ones to an acknowledge register.

A snapshot stays frozen while its primary flag is pending. A later error of the same class only sets a separate second-error flag, so the first failure is never overwritten. An options register selects the ECC mode, which gates all logging. It also arms a one-shot corruption of the write path: while armed, an 8-bit mask is presented for XOR into the check bits of the next memory write. The arm bit clears itself once that write has happened.

Software reaches everything through a simple register port. It has a bank select (0 = error bank, 1 = interrupt bank), a byte offset, a write strobe with write data, and read data that is combinational by default.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every readable register returns zero, `irq` is low and `inj_xor` is zero.
- R2: The error bank (bank 0) decodes these byte offsets:
  - 0x00: options
  - 0x08: uncorrectable address
  - 0x0C: uncorrectable status
  - 0x10: uncorrectable data bits 31:0
  - 0x14: uncorrectable data bits 63:32
  - 0x18: correctable address
  - 0x1C: correctable status
  - 0x20: correctable data bits 31:0
  - 0x24: correctable data bits 63:32
- R3: The interrupt status register is at bank 1, offset 0x00. Its bits are: bit 3 correctable, bit 4 second correctable, bit 5 uncorrectable, bit 6 second uncorrectable. `irq` is high exactly when any of these bits is set.
- R4: A write to bank 1, offset 0x04 clears each status bit whose position is 1 in the written value. The acknowledge register reads as zero.
- R5: A logged correctable error stores its address, its syndrome in status bits 15:8, and its data halves, one cycle after the report.
- R6: A logged uncorrectable error stores its address, its syndrome in status bits 15:8, and its data halves in the uncorrectable set, one cycle after the report.
- R7: While a class's primary flag is set and not being acknowledged, that class's registers are frozen. A new error of that class sets only its second-error bit. Once the primary flag is acknowledged, the next error is captured again.
- R8: A correctable and an uncorrectable error reported in the same cycle are both logged, each in its own set.
- R9: When options bits 1:0 hold 0 or 2, no error is logged and no status bit is set.
- R10: The options fields are: bits 1:0 mode, bit 8 arm, bits 23:16 mask.
  - While arm is set, `inj_xor` equals the mask; otherwise it is zero.
  - A cycle with `wr_fire` high clears arm, so exactly one write is corrupted.
  - Mode and mask keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_bank | input | 1 | Register bank select: 0 error bank, 1 interrupt bank |
| reg_off | input | 8 | Byte offset within the bank |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| chk_ce | input | 1 | Checker reports a correctable error |
| chk_ue | input | 1 | Checker reports an uncorrectable error |
| chk_addr | input | 32 | Address of the checked read |
| chk_synd | input | 8 | Syndrome of the checked read |
| chk_data | input | 64 | Raw data of the checked read |
| wr_fire | input | 1 | A memory write takes its check bits this cycle |
| inj_xor | output | 8 | Mask to XOR into the check bits of the current write |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The capture path is tried with a correctable-only report, an uncorrectable-only report, and a report carrying both flags. The data words use distinct high and low halves, which shows whether each class lands in its own register set with its halves in the right order.

Back-to-back errors of the same class separate a correct freeze from an overwrite. A partial acknowledge that clears only the primary bit separates the second-error flag from the primary one. Both disabled mode values are applied before logging is enabled. Two consecutive writes after arming show that the injection mask touches exactly one write.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int REG_W = 32;

   // error bank byte offsets
   localparam logic [7:0] OFF_OPT    = 8'h00;
   localparam logic [7:0] OFF_U_ADDR = 8'h08;
   localparam logic [7:0] OFF_U_STAT = 8'h0C;
   localparam logic [7:0] OFF_U_DLO  = 8'h10;
   localparam logic [7:0] OFF_U_DHI  = 8'h14;
   localparam logic [7:0] OFF_C_ADDR = 8'h18;
   localparam logic [7:0] OFF_C_STAT = 8'h1C;
   localparam logic [7:0] OFF_C_DLO  = 8'h20;
   localparam logic [7:0] OFF_C_DHI  = 8'h24;

   // interrupt bank byte offsets
   localparam logic [7:0] OFF_INT_STAT = 8'h00;
   localparam logic [7:0] OFF_INT_ACK  = 8'h04;

   // interrupt status bit positions
   localparam int IB_CE  = 3;
   localparam int IB_CE2 = 4;
   localparam int IB_UE  = 5;
   localparam int IB_UE2 = 6;

   // options field positions
   localparam int OPT_ARM_BIT = 8;
   localparam int OPT_MASK_LO = 16;
   localparam int STAT_SYND_LO = 8;

   // class index used by the snapshot generate loop
   localparam int CLS_CE = 0;
   localparam int CLS_UE = 1;
   localparam int N_CLS  = 2;
endpackage

// File: rtl/ecc_err_slot.sv
module ecc_err_slot #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int SYND_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              log_en,
   input  logic              err,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [SYND_W-1:0] err_synd,
   input  logic [DATA_W-1:0] err_data,
   input  logic              ack_prim,
   input  logic              ack_sec,
   output logic              prim_q,
   output logic              sec_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [SYND_W-1:0] synd_q,
   output logic [DATA_W-1:0] data_q
);
   logic hit;
   logic take;
   logic again;

   assign hit   = log_en && err;
   assign take  = hit && (!prim_q || ack_prim);
   assign again = hit && prim_q && !ack_prim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prim_q <= 1'b0;
         sec_q  <= 1'b0;
         addr_q <= '0;
         synd_q <= '0;
         data_q <= '0;
      end else begin
         prim_q <= take || (prim_q && !ack_prim);
         sec_q  <= again || (sec_q && !ack_sec);
         if (take) begin
            addr_q <= err_addr;
            synd_q <= err_synd;
            data_q <= err_data;
         end
      end
   end

   assert_snapshot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prim_q && !ack_prim) |=> ($stable(addr_q) && $stable(synd_q) && $stable(data_q)));

   assert_second_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (log_en && err && prim_q && !ack_prim) |=> (sec_q && prim_q));

   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (log_en && err && !prim_q) |=> (prim_q && addr_q == $past(err_addr)));
endmodule

// File: rtl/ecc_opt_reg.sv
module ecc_opt_reg #(
   parameter int SYND_W = 8,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              opt_wr,
   input  logic [REG_W-1:0]  opt_wdata,
   input  logic              wr_fire,
   output logic [1:0]        mode_q,
   output logic              arm_q,
   output logic [SYND_W-1:0] mask_q,
   output logic              log_en,
   output logic [SYND_W-1:0] inj_xor
);
   import ecc_log_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 2'b00;
         arm_q  <= 1'b0;
         mask_q <= '0;
      end else if (opt_wr) begin
         mode_q <= opt_wdata[1:0];
         arm_q  <= opt_wdata[OPT_ARM_BIT];
         mask_q <= opt_wdata[OPT_MASK_LO +: SYND_W];
      end else if (wr_fire) begin
         arm_q  <= 1'b0;
      end
   end

   // modes 0 and 2 disable checking
   assign log_en  = mode_q[0];
   assign inj_xor = arm_q ? mask_q : '0;

   assert_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && wr_fire && !opt_wr) |=> (!arm_q && $stable(mask_q) && $stable(mode_q)));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64,
   parameter int SYND_W  = 8,
   parameter int OFF_W   = 8,
   parameter bit RD_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_bank,
   input  logic [OFF_W-1:0]  reg_off,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              chk_ce,
   input  logic              chk_ue,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [SYND_W-1:0] chk_synd,
   input  logic [DATA_W-1:0] chk_data,
   input  logic              wr_fire,
   output logic [SYND_W-1:0] inj_xor,
   output logic              irq
);
   import ecc_log_pkg::*;

   localparam int HALF_W = DATA_W / 2;

   generate
      if (DATA_W != 2 * REG_W) begin : g_bad_data
         $error("DATA_W must be two register words");
      end
      if (ADDR_W > REG_W || ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must fit one register word");
      end
      if (SYND_W > 8 || SYND_W < 1) begin : g_bad_synd
         $error("SYND_W must fit the status syndrome field");
      end
      if (OFF_W < 8) begin : g_bad_off
         $error("OFF_W must cover offset 0x24");
      end
   endgenerate

   logic [7:0] off8;
   assign off8 = reg_off[7:0];

   logic opt_wr;
   logic ack_wr;
   assign opt_wr = reg_wr && !reg_bank && off8 == OFF_OPT;
   assign ack_wr = reg_wr &&  reg_bank && off8 == OFF_INT_ACK;

   logic [1:0]        mode_q;
   logic              arm_q;
   logic [SYND_W-1:0] mask_q;
   logic              log_en;

   ecc_opt_reg #(.SYND_W(SYND_W), .REG_W(REG_W)) u_opt (
      .clk      (clk),
      .rst_n    (rst_n),
      .opt_wr   (opt_wr),
      .opt_wdata(reg_wdata),
      .wr_fire  (wr_fire),
      .mode_q   (mode_q),
      .arm_q    (arm_q),
      .mask_q   (mask_q),
      .log_en   (log_en),
      .inj_xor  (inj_xor)
   );

   logic [N_CLS-1:0] cls_err;
   logic [N_CLS-1:0] cls_ack_p;
   logic [N_CLS-1:0] cls_ack_s;
   logic [N_CLS-1:0] cls_prim;
   logic [N_CLS-1:0] cls_sec;
   logic [ADDR_W-1:0] cls_addr [N_CLS];
   logic [SYND_W-1:0] cls_synd [N_CLS];
   logic [DATA_W-1:0] cls_data [N_CLS];

   assign cls_err[CLS_CE]   = chk_ce;
   assign cls_err[CLS_UE]   = chk_ue;
   assign cls_ack_p[CLS_CE] = ack_wr && reg_wdata[IB_CE];
   assign cls_ack_s[CLS_CE] = ack_wr && reg_wdata[IB_CE2];
   assign cls_ack_p[CLS_UE] = ack_wr && reg_wdata[IB_UE];
   assign cls_ack_s[CLS_UE] = ack_wr && reg_wdata[IB_UE2];

   generate
      for (genvar c = 0; c < N_CLS; c++) begin : g_cls
         ecc_err_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYND_W(SYND_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .log_en  (log_en),
            .err     (cls_err[c]),
            .err_addr(chk_addr),
            .err_synd(chk_synd),
            .err_data(chk_data),
            .ack_prim(cls_ack_p[c]),
            .ack_sec (cls_ack_s[c]),
            .prim_q  (cls_prim[c]),
            .sec_q   (cls_sec[c]),
            .addr_q  (cls_addr[c]),
            .synd_q  (cls_synd[c]),
            .data_q  (cls_data[c])
         );
      end
   endgenerate

   logic [REG_W-1:0] int_stat;
   always_comb begin
      int_stat         = '0;
      int_stat[IB_CE]  = cls_prim[CLS_CE];
      int_stat[IB_CE2] = cls_sec[CLS_CE];
      int_stat[IB_UE]  = cls_prim[CLS_UE];
      int_stat[IB_UE2] = cls_sec[CLS_UE];
   end
   assign irq = |int_stat;

   // widen stored fields to register words
   logic [REG_W-1:0] addr_w [N_CLS];
   logic [REG_W-1:0] stat_w [N_CLS];
   logic [REG_W-1:0] opt_w;
   always_comb begin
      for (int c = 0; c < N_CLS; c++) begin
         addr_w[c] = '0;
         addr_w[c][ADDR_W-1:0] = cls_addr[c];
         stat_w[c] = '0;
         stat_w[c][STAT_SYND_LO +: SYND_W] = cls_synd[c];
      end
      opt_w = '0;
      opt_w[1:0] = mode_q;
      opt_w[OPT_ARM_BIT] = arm_q;
      opt_w[OPT_MASK_LO +: SYND_W] = mask_q;
   end

   logic [REG_W-1:0] rd_comb;
   always_comb begin
      rd_comb = '0;
      if (reg_bank) begin
         if (off8 == OFF_INT_STAT) rd_comb = int_stat;
      end else begin
         case (off8)
            OFF_OPT:    rd_comb = opt_w;
            OFF_U_ADDR: rd_comb = addr_w[CLS_UE];
            OFF_U_STAT: rd_comb = stat_w[CLS_UE];
            OFF_U_DLO:  rd_comb = cls_data[CLS_UE][HALF_W-1:0];
            OFF_U_DHI:  rd_comb = cls_data[CLS_UE][DATA_W-1:HALF_W];
            OFF_C_ADDR: rd_comb = addr_w[CLS_CE];
            OFF_C_STAT: rd_comb = stat_w[CLS_CE];
            OFF_C_DLO:  rd_comb = cls_data[CLS_CE][HALF_W-1:0];
            OFF_C_DHI:  rd_comb = cls_data[CLS_CE][DATA_W-1:HALF_W];
            default:    rd_comb = '0;
         endcase
      end
   end

   generate
      if (RD_FLOP) begin : g_rd_flop
         logic [REG_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_comb;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_comb;
      end
   endgenerate

   assert_irq_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && ((int_stat & ~reg_wdata) == '0) && !chk_ce && !chk_ue) |=> !irq);

   assert_no_log_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!log_en && !irq) |=> !irq);

   assert_both_classes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (log_en && chk_ce && chk_ue) |=> (cls_prim[CLS_CE] && cls_prim[CLS_UE]));
endmodule

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
   localparam int CLK_P = 10;
   localparam int NV = 4;

   // entry: {ce, ue, addr[31:0], synd[7:0], data[63:0]}
   localparam logic [105:0] VEC [NV] = '{
      {1'b1, 1'b0, 32'h1000_0040, 8'h3C, 64'h0123_4567_89AB_CDEF},
      {1'b0, 1'b1, 32'h7FFF_FFF8, 8'hC1, 64'hDEAD_BEEF_0BAD_F00D},
      {1'b1, 1'b1, 32'h0000_0008, 8'h01, 64'hFFFF_FFFF_0000_0000},
      {1'b1, 1'b0, 32'hFFFF_FFF8, 8'hFF, 64'h0000_0000_0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_bank = 1'b0;
   logic [7:0]  reg_off = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        chk_ce = 1'b0;
   logic        chk_ue = 1'b0;
   logic [31:0] chk_addr = '0;
   logic [7:0]  chk_synd = '0;
   logic [63:0] chk_data = '0;
   logic        wr_fire = 1'b0;
   logic [7:0]  inj_xor;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   ecc_err_log u_dut (
      .clk(clk), .rst_n(rst_n), .reg_bank(reg_bank), .reg_off(reg_off),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .chk_ce(chk_ce), .chk_ue(chk_ue), .chk_addr(chk_addr),
      .chk_synd(chk_synd), .chk_data(chk_data), .wr_fire(wr_fire),
      .inj_xor(inj_xor), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic bank, input logic [7:0] off, input logic [31:0] d);
      @(negedge clk);
      reg_bank = bank; reg_off = off; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic do_read(input logic bank, input logic [7:0] off, output logic [31:0] d);
      reg_bank = bank; reg_off = off;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_chk(input string tag, input logic bank, input logic [7:0] off,
                         input logic [31:0] exp);
      logic [31:0] v;
      do_read(bank, off, v);
      chk(tag, v, exp);
   endtask

   task automatic err_pulse(input logic ce, input logic ue, input logic [31:0] a,
                            input logic [7:0] s, input logic [63:0] d);
      @(negedge clk);
      chk_ce = ce; chk_ue = ue; chk_addr = a; chk_synd = s; chk_data = d;
      @(negedge clk);
      chk_ce = 1'b0; chk_ue = 1'b0; chk_addr = '0; chk_synd = '0; chk_data = '0;
   endtask

   task automatic fire_write();
      @(negedge clk);
      wr_fire = 1'b1;
      @(negedge clk);
      wr_fire = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 inj_xor", {24'b0, inj_xor}, 32'h0);
      for (int o = 0; o <= 9; o++) begin
         logic [7:0] off;
         off = (o == 0) ? 8'h00 : 8'(o * 4 + 4);
         rd_chk("R1 err bank", 1'b0, off, 32'h0);
      end
      rd_chk("R1 int stat", 1'b1, 8'h00, 32'h0);

      // R9: mode 0 (reset) and mode 2 log nothing
      err_pulse(1'b1, 1'b1, 32'hAAAA_0000, 8'h11, 64'h1);
      chk("R9 mode0 irq", {31'b0, irq}, 32'h0);
      rd_chk("R9 mode0 ce addr", 1'b0, 8'h18, 32'h0);
      do_write(1'b0, 8'h00, 32'h0000_0002);
      err_pulse(1'b1, 1'b1, 32'hBBBB_0000, 8'h22, 64'h2);
      chk("R9 mode2 irq", {31'b0, irq}, 32'h0);
      rd_chk("R9 mode2 int stat", 1'b1, 8'h00, 32'h0);
      rd_chk("R9 mode2 ue addr", 1'b0, 8'h08, 32'h0);

      // enable ECC mode 1
      do_write(1'b0, 8'h00, 32'h0000_0001);
      rd_chk("R10 opt mode", 1'b0, 8'h00, 32'h0000_0001);

      // R2 R3 R4 R5 R6 R8: table walk
      for (int i = 0; i < NV; i++) begin
         logic ce, ue;
         logic [31:0] a;
         logic [7:0] s;
         logic [63:0] d;
         logic [31:0] exp_st;
         {ce, ue, a, s, d} = VEC[i];
         exp_st = (ce ? 32'h08 : 32'h0) | (ue ? 32'h20 : 32'h0);
         err_pulse(ce, ue, a, s, d);
         rd_chk("R3 R8 int stat", 1'b1, 8'h00, exp_st);
         chk("R3 irq high", {31'b0, irq}, 32'h1);
         if (ce) begin
            rd_chk("R5 R2 ce addr", 1'b0, 8'h18, a);
            rd_chk("R5 R2 ce stat", 1'b0, 8'h1C, {16'b0, s, 8'b0});
            rd_chk("R5 R2 ce dlo", 1'b0, 8'h20, d[31:0]);
            rd_chk("R5 R2 ce dhi", 1'b0, 8'h24, d[63:32]);
         end
         if (ue) begin
            rd_chk("R6 R2 ue addr", 1'b0, 8'h08, a);
            rd_chk("R6 R2 ue stat", 1'b0, 8'h0C, {16'b0, s, 8'b0});
            rd_chk("R6 R2 ue dlo", 1'b0, 8'h10, d[31:0]);
            rd_chk("R6 R2 ue dhi", 1'b0, 8'h14, d[63:32]);
         end
         do_write(1'b1, 8'h04, exp_st);
         rd_chk("R4 stat cleared", 1'b1, 8'h00, 32'h0);
         rd_chk("R4 ack reads zero", 1'b1, 8'h04, 32'h0);
         chk("R4 irq low", {31'b0, irq}, 32'h0);
      end

      // R7: freeze and second-error flag
      err_pulse(1'b1, 1'b0, 32'h0000_1110, 8'h5A, 64'h1111_2222_3333_4444);
      err_pulse(1'b1, 1'b0, 32'h0000_2220, 8'hA5, 64'h5555_6666_7777_8888);
      rd_chk("R7 second flag", 1'b1, 8'h00, 32'h18);
      rd_chk("R7 addr frozen", 1'b0, 8'h18, 32'h0000_1110);
      rd_chk("R7 synd frozen", 1'b0, 8'h1C, 32'h0000_5A00);
      rd_chk("R7 data frozen", 1'b0, 8'h24, 32'h1111_2222);
      do_write(1'b1, 8'h04, 32'h08);
      rd_chk("R4 partial ack", 1'b1, 8'h00, 32'h10);
      chk("R3 irq from second", {31'b0, irq}, 32'h1);
      err_pulse(1'b1, 1'b0, 32'h0000_3330, 8'h33, 64'h9);
      rd_chk("R7 recapture stat", 1'b1, 8'h00, 32'h18);
      rd_chk("R7 recapture addr", 1'b0, 8'h18, 32'h0000_3330);
      do_write(1'b1, 8'h04, 32'h18);
      chk("R4 irq after full ack", {31'b0, irq}, 32'h0);

      // R7 uncorrectable second error
      err_pulse(1'b0, 1'b1, 32'h0000_4440, 8'h44, 64'h4);
      err_pulse(1'b0, 1'b1, 32'h0000_5550, 8'h55, 64'h5);
      rd_chk("R7 ue second flag", 1'b1, 8'h00, 32'h60);
      rd_chk("R7 ue addr frozen", 1'b0, 8'h08, 32'h0000_4440);
      do_write(1'b1, 8'h04, 32'h60);
      rd_chk("R4 ue cleared", 1'b1, 8'h00, 32'h0);

      // R10: one-shot injection
      chk("R10 unarmed xor", {24'b0, inj_xor}, 32'h0);
      do_write(1'b0, 8'h00, 32'h00A5_0101);
      chk("R10 armed xor", {24'b0, inj_xor}, 32'h0000_00A5);
      rd_chk("R10 opt armed", 1'b0, 8'h00, 32'h00A5_0101);
      fire_write();
      chk("R10 xor after write", {24'b0, inj_xor}, 32'h0);
      rd_chk("R10 opt after write", 1'b0, 8'h00, 32'h00A5_0001);
      fire_write();
      chk("R10 second write clean", {24'b0, inj_xor}, 32'h0);
      err_pulse(1'b1, 1'b0, 32'h0000_6660, 8'h66, 64'h6);
      rd_chk("R10 mode kept logging", 1'b1, 8'h00, 32'h08);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule